// File: doc/BRIEF.md
# Configurable Command/Address Registered Buffer

This block registers a wide command/address word for a memory module on each rising clock edge. Two static strap inputs select its shape. With the fan-out strap low it is a one-to-one register over 25 lanes. With the strap high it keeps 14 lanes, and every registered lane drives a matching output in both an A bank and a B bank. A second strap then picks one of two lane layouts.

The data lanes load only when at least one of the two active-low select inputs is low. The select, on-die-termination and clock-enable lanes load on every edge, whatever the selects are. Tying the rank select low defeats the gating, so the direct select then acts like any other registered input.

An active-low reset clears every register and forces every output low at once, without waiting for a clock edge. Reset release passes through a two-stage synchronizer. Disabled B-bank outputs and lanes the current layout does not use are driven to zero.

Top module: `cmd_regbuf`

## Requirements
- R1: With `cfgFanout`=0, on each rising edge where loading is enabled, `qDataA` captures `dIn` on every lane except lanes 0, 3 and 6, and those three lanes read 0.
- R2: When both `csDirN` and `csRankN` are 1 at a rising edge, `qDataA` and `qDataB` keep their previous values. When either is 0, the data lanes load.
- R3: `qCsA_n`, `qOdtA` and `qCkeA` register `csDirN`, `odtIn` and `ckeIn` on every rising edge after reset release, independent of the selects.
- R4: While `rstN` is 0, every output is 0. This takes effect asynchronously and overrides the select gating.
- R5: After `rstN` rises, the first two rising edges load nothing and all outputs stay 0. The third edge is the first edge that loads.
- R6: With `cfgFanout`=1 and `cfgLayout`=0, only lanes 1, 2, 4, 5 and 7 to 13 are active, and all other lanes read 0. Every B output equals its A counterpart.
- R7: With `cfgFanout`=1 and `cfgLayout`=1, only lanes 0 to 5, 7, 8, 9, 11 and 12 are active, and all other lanes read 0. Every B output equals its A counterpart.
- R8: With `cfgFanout`=0, `qDataB`, `qCsB_n`, `qOdtB` and `qCkeB` are all 0.
- R9: With `csRankN` held at 0, data lanes load on every edge whatever the value of `csDirN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| cfgFanout | input | 1 | Strap: 0 = one-to-one, 1 = one-to-two |
| cfgLayout | input | 1 | Strap: lane layout in one-to-two mode (0 = A, 1 = B) |
| dIn | input | 25 | Data lanes |
| csDirN | input | 1 | Direct chip select, active low |
| csRankN | input | 1 | Rank chip select, active low |
| odtIn | input | 1 | Termination control lane |
| ckeIn | input | 1 | Clock-enable lane |
| qDataA | output | 25 | Registered data, A bank |
| qDataB | output | 25 | Registered data, B bank |
| qCsA_n | output | 1 | Registered direct select, A bank |
| qCsB_n | output | 1 | Registered direct select, B bank |
| qOdtA | output | 1 | Registered termination lane, A bank |
| qOdtB | output | 1 | Registered termination lane, B bank |
| qCkeA | output | 1 | Registered clock-enable lane, A bank |
| qCkeB | output | 1 | Registered clock-enable lane, B bank |

## Verification
Select gating and the control-lane update share every clock edge. In a gated cycle, the data lanes must hold while the select, termination and clock-enable lanes still take new values. The bench drives random select pairs with random data, so held and loaded cycles interleave, and it compares data and control lanes against a model as separate checks.

Reset can land in the middle of a gated or loading cycle, and it must win. The bench drops `rstN` at random half-cycle points and checks for all-zero outputs one nanosecond later. While the synchronizer window runs, it keeps the inputs non-zero to show that nothing loads early.

// File: rtl/cmd_regbuf_pkg.sv
package cmd_regbuf_pkg;
  localparam int LANES      = 25;
  localparam int NARROW     = 14;
  localparam int SKIP_A     = 0;
  localparam int SKIP_B     = 3;
  localparam int SKIP_C     = 6;
  localparam int B_ODT_SLOT = 10;

  typedef struct packed {
    logic             run;
    logic             loadData;
    logic             fanout;
    logic [LANES-1:0] laneMask;
  } regbuf_strobe_t;

  function automatic logic [LANES-1:0] activeLanes(input logic fanout, input logic layoutB);
    logic [LANES-1:0] m;
    for (int i = 0; i < LANES; i++) begin
      if (!fanout)
        m[i] = (i != SKIP_A) && (i != SKIP_B) && (i != SKIP_C);
      else if (!layoutB)
        m[i] = (i < NARROW) && (i != SKIP_A) && (i != SKIP_B) && (i != SKIP_C);
      else
        m[i] = (i < NARROW - 1) && (i != SKIP_C) && (i != B_ODT_SLOT);
    end
    return m;
  endfunction
endpackage

// File: rtl/cmd_regbuf_ctrl.sv
module cmd_regbuf_ctrl
  import cmd_regbuf_pkg::*;
(
  input  logic           clk,
  input  logic           rstN,
  input  logic           cfgFanout,
  input  logic           cfgLayout,
  input  logic           csDirN,
  input  logic           csRankN,
  output regbuf_strobe_t stb
);
  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] syncQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '0;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], 1'b1};
  end

  always_comb begin
    stb.run      = syncQ[SYNC_STAGES-1];
    stb.loadData = syncQ[SYNC_STAGES-1] & ~(csDirN & csRankN);
    stb.fanout   = cfgFanout;
    stb.laneMask = activeLanes(cfgFanout, cfgLayout);
  end

  // R9: a low rank select alone must enable the data load once running
  assert_rank_low_loads_R9: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && !csRankN) |-> stb.loadData);
endmodule

// File: rtl/cmd_regbuf_dp.sv
module cmd_regbuf_dp
  import cmd_regbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  regbuf_strobe_t   stb,
  input  logic [LANES-1:0] dIn,
  input  logic             csDirN,
  input  logic             odtIn,
  input  logic             ckeIn,
  output logic [LANES-1:0] qDataA,
  output logic [LANES-1:0] qDataB,
  output logic             qCsA_n,
  output logic             qCsB_n,
  output logic             qOdtA,
  output logic             qOdtB,
  output logic             qCkeA,
  output logic             qCkeB
);
  logic [LANES-1:0] dataReg;
  logic             csReg, odtReg, ckeReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      csReg   <= 1'b0;
      odtReg  <= 1'b0;
      ckeReg  <= 1'b0;
    end else if (stb.run) begin
      csReg  <= csDirN;
      odtReg <= odtIn;
      ckeReg <= ckeIn;
      if (stb.loadData) dataReg <= dIn & stb.laneMask;
    end
  end

  assign qDataA = dataReg;
  assign qCsA_n = csReg;
  assign qOdtA  = odtReg;
  assign qCkeA  = ckeReg;

  generate
    for (genvar g = 0; g < LANES; g++) begin : gBank
      assign qDataB[g] = stb.fanout & dataReg[g];
    end
  endgenerate
  assign qCsB_n = stb.fanout & csReg;
  assign qOdtB  = stb.fanout & odtReg;
  assign qCkeB  = stb.fanout & ckeReg;

  assert_gate_hold_R2: assert property (@(posedge clk) disable iff (!rstN)
    (stb.run && !stb.loadData) |=> $stable(qDataA));
  assert_ctrl_follow_R3: assert property (@(posedge clk) disable iff (!rstN)
    stb.run |=> (qOdtA == $past(odtIn)) && (qCkeA == $past(ckeIn)) && (qCsA_n == $past(csDirN)));
  assert_reset_clear_R4: assert property (@(posedge clk)
    !rstN |-> (qDataA == '0) && !qCsA_n && !qOdtA && !qCkeA && (qDataB == '0));
  assert_b_mirror_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.fanout |-> (qDataB == qDataA) && (qCsB_n == qCsA_n) && (qOdtB == qOdtA) && (qCkeB == qCkeA));
  assert_b_off_R8: assert property (@(posedge clk) disable iff (!rstN)
    !stb.fanout |-> (qDataB == '0) && !qCsB_n && !qOdtB && !qCkeB);
  assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rstN)
    (qDataA & ~stb.laneMask) == '0);
endmodule

// File: rtl/cmd_regbuf.sv
module cmd_regbuf
  import cmd_regbuf_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgFanout,
  input  logic             cfgLayout,
  input  logic [LANES-1:0] dIn,
  input  logic             csDirN,
  input  logic             csRankN,
  input  logic             odtIn,
  input  logic             ckeIn,
  output logic [LANES-1:0] qDataA,
  output logic [LANES-1:0] qDataB,
  output logic             qCsA_n,
  output logic             qCsB_n,
  output logic             qOdtA,
  output logic             qOdtB,
  output logic             qCkeA,
  output logic             qCkeB
);
  regbuf_strobe_t stb;

  cmd_regbuf_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cfgFanout(cfgFanout), .cfgLayout(cfgLayout),
    .csDirN(csDirN), .csRankN(csRankN), .stb(stb)
  );

  cmd_regbuf_dp u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .dIn(dIn), .csDirN(csDirN),
    .odtIn(odtIn), .ckeIn(ckeIn),
    .qDataA(qDataA), .qDataB(qDataB), .qCsA_n(qCsA_n), .qCsB_n(qCsB_n),
    .qOdtA(qOdtA), .qOdtB(qOdtB), .qCkeA(qCkeA), .qCkeB(qCkeB)
  );
endmodule

// File: tb/cmd_regbuf_tb.sv
module cmd_regbuf_tb;
  logic        clk = 0;
  logic        rstN = 0;
  logic        cfgFanout = 0, cfgLayout = 0;
  logic [24:0] dIn = '0;
  logic        csDirN = 1, csRankN = 1, odtIn = 0, ckeIn = 0;
  logic [24:0] qDataA, qDataB;
  logic        qCsA_n, qCsB_n, qOdtA, qOdtB, qCkeA, qCkeB;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  always #4 clk = ~clk;

  cmd_regbuf u_dut (.*);

  typedef struct {
    logic [24:0] d;
    logic cs, odt, cke;
    bit   fan;
    string tagData;
  } exp_t;
  exp_t expQ[$];

  logic [24:0] mData;
  logic mCs, mOdt, mCke;
  int   relCnt = 0;

  function automatic logic [24:0] benchMask(bit fan, bit lay);
    logic [24:0] m;
    if (!fan) m = {25{1'b1}};
    else if (!lay) m = 25'h0003FFF;
    else begin
      m = '0;
      m[0] = 1; m[1] = 1; m[2] = 1; m[3] = 1; m[4] = 1; m[5] = 1;
      m[7] = 1; m[8] = 1; m[9] = 1; m[11] = 1; m[12] = 1;
    end
    if (!lay || !fan) begin m[0] = 0; m[3] = 0; m[6] = 0; end
    return m;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic cycle(logic [24:0] d, logic dcs, logic csr, logic odt, logic cke, logic rstv);
    exp_t e;
    @(negedge clk);
    dIn = d; csDirN = dcs; csRankN = csr; odtIn = odt; ckeIn = cke;
    if (!rstv && rstN) begin
      rstN = 0;
      #1;
      check("R4 async data", {7'd0, qDataA}, 32'd0);
      check("R4 async ctrl", {26'd0, qCsA_n, qOdtA, qCkeA, qCsB_n, qOdtB, qCkeB}, 32'd0);
    end
    rstN = rstv;
    @(posedge clk);
    if (!rstN) begin
      mData = '0; mCs = 0; mOdt = 0; mCke = 0; relCnt = 0;
      e.tagData = "R4";
    end else if (relCnt < 2) begin
      relCnt++;
      e.tagData = "R5";
    end else begin
      mCs = dcs; mOdt = odt; mCke = cke;
      if (!(dcs && csr)) mData = d & benchMask(cfgFanout, cfgLayout);
      if (dcs && csr) e.tagData = "R2";
      else if (!csr) e.tagData = "R9";
      else if (!cfgFanout) e.tagData = "R1";
      else e.tagData = cfgLayout ? "R7" : "R6";
    end
    e.d = mData; e.cs = mCs; e.odt = mOdt; e.cke = mCke; e.fan = cfgFanout;
    #1 expQ.push_back(e);
  endtask

  // monitor: pops expected items and compares as results appear
  always @(posedge clk) begin
    #3;
    while (expQ.size() > 0) begin
      exp_t e;
      e = expQ.pop_front();
      check({e.tagData, " dataA"}, {7'd0, qDataA}, {7'd0, e.d});
      check("R3 ctrl lanes A", {29'd0, qCsA_n, qOdtA, qCkeA}, {29'd0, e.cs, e.odt, e.cke});
      if (e.fan)
        check("R6 B mirror", {4'd0, qDataB, qCsB_n, qOdtB, qCkeB}, {4'd0, e.d, e.cs, e.odt, e.cke});
      else
        check("R8 B off", {4'd0, qDataB, qCsB_n, qOdtB, qCkeB}, 32'd0);
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 50000 && !done) begin
      errors++;
      $display("FAIL watchdog expired actual=%0d expected<=50000", cycles);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  task automatic resetEpisode(bit fan, bit lay);
    cycle('1, 0, 0, 1, 1, 0);
    cycle('1, 0, 0, 1, 1, 0);
    cfgFanout = fan; cfgLayout = lay;
    cycle('1, 0, 0, 1, 1, 0);
    // R5: non-zero inputs during the synchronizer window must not load
    cycle('1, 0, 0, 1, 1, 1);
    cycle('1, 0, 0, 1, 1, 1);
  endtask

  initial begin
    #1;
    check("R4 reset state", {7'd0, qDataA}, 32'd0);
    for (int c = 0; c < 3; c++) begin
      bit fan = (c != 0);
      bit lay = (c == 2);
      resetEpisode(fan, lay);
      cycle(25'h1FFFFFF, 0, 1, 1, 0, 1);
      cycle(25'h0AAAAAA, 1, 1, 0, 1, 1);   // R2: gated, control still updates
      cycle(25'h1555555, 1, 0, 1, 1, 1);   // R9: rank low defeats gating
      for (int k = 0; k < 400; k++) begin
        logic [1:0] cs = 2'($urandom);
        bit rst = ($urandom % 40) != 0;
        cycle(25'($urandom), cs[0], cs[1], 1'($urandom), 1'($urandom), rst);
      end
      for (int k = 0; k < 40; k++)        // R9: rank select tied low
        cycle(25'($urandom), 1'($urandom), 0, 1'($urandom), 1'($urandom), 1);
    end
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule